// File: doc/BRIEF.md
# Handshaked Byte Input Port with Polled Ready Flag

This block sits between a slow peripheral that produces bytes and a processor that collects them by polling. The peripheral puts a byte on its data lines and raises a valid line. The port copies the byte into a holding register, raises an accepted line back to the peripheral, and sets a ready flag. The peripheral then lowers valid, and the port lowers accepted one clock later. That four-phase exchange is complete, and the peripheral may offer the next byte.

The processor has a small read port with a one-bit address. Address 0 returns a status word whose bit 0 is the ready flag. Address 1 returns the holding register. A read strobe at address 1 empties the holding register logically by clearing the flag. While the flag is set, the port withholds accepted from any new byte. The peripheral is therefore held off until software has taken the previous byte, and no byte is ever overwritten.

The handshake is run by a three-state machine:
- `HS_IDLE`: no transfer is in progress.
- `HS_ACCEPT`: a byte has been taken and accepted is driven.
- `HS_WAIT_ROOM`: a byte is offered but the holding register is still full.

The transitions are named as follows:
- `take`: IDLE or WAIT_ROOM goes to ACCEPT when valid is high and the flag is clear.
- `stall`: IDLE goes to WAIT_ROOM when valid is high and the flag is set.
- `release`: ACCEPT goes to IDLE when valid is low.
- `withdraw`: WAIT_ROOM goes to IDLE when valid is low.

Top module: `hs_input_port`

## Requirements
- R1: While reset is asserted, and directly after it is released, accepted is 0, the ready flag (status bit 0) is 0 and the holding register reads 0.
- R2: When valid is high at a clock edge while no transfer is in progress and the flag is clear, that edge loads the byte into the holding register and sets the flag, and accepted is 1 after the edge.
- R3: Accepted stays 1 for as long as valid is sampled high. It returns to 0 at the first clock edge at which valid is sampled low.
- R4: While the flag is set, accepted is not raised for a new byte and the holding register keeps its value.
- R5: A read at address 0 returns the flag in bit 0 and zeros in all higher bits. A read strobe at address 0 leaves the flag unchanged.
- R6: A read at address 1 returns the holding register. A read strobe at address 1 while the flag is set clears the flag at that clock edge.
- R7: A byte that was held off by a full register is taken at the first clock edge after the edge that cleared the flag, provided valid is still high.
- R8: If the peripheral lowers valid while it is held off, the port returns to idle without taking the byte or raising accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_data | input | DATA_W | Byte offered by the peripheral |
| dev_valid | input | 1 | Peripheral says dev_data is valid |
| dev_accept | output | 1 | Port has taken the byte |
| cpu_addr | input | 1 | 0 selects status, 1 selects holding register |
| cpu_rd | input | 1 | Read strobe; at address 1 it clears the flag |
| cpu_rdata | output | DATA_W | Combinational read data |

## Verification
All 256 byte values go through complete handshakes, with valid held high for one to three cycles. This sweep separates a correct capture and release from stuck data bits and from an accepted line that drops early or late.

A second byte is then offered while the first has not yet been read. This back-pressure pattern shows whether the port overwrites, raises accepted too early, or fails to pick the pending byte up one cycle after the read.

Two further patterns cover the remaining cases. In one, the pending byte is withdrawn, which tells the withdraw transition apart from a hidden capture. In the other, strobes are issued at the status address, which tells a clear decoded from the address apart from one that fires on any strobe.

// File: rtl/hs_in_pkg.sv
package hs_in_pkg;

    typedef enum logic [1:0] {
        HS_IDLE      = 2'd0,
        HS_ACCEPT    = 2'd1,
        HS_WAIT_ROOM = 2'd2
    } hs_state_e;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_DATA   = 1'b1;

endpackage

// File: rtl/hs_capture_fsm.sv
module hs_capture_fsm
    import hs_in_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_valid,
    input  logic reg_full,
    output logic take_byte,
    output logic dev_accept
);

    hs_state_e state_q;
    hs_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: take, stall, release, withdraw
    always_comb begin
        state_d   = state_q;
        take_byte = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (dev_valid) begin
                    if (!reg_full) begin
                        state_d   = HS_ACCEPT;   // take
                        take_byte = 1'b1;
                    end else begin
                        state_d   = HS_WAIT_ROOM; // stall
                    end
                end
            end
            HS_ACCEPT: begin
                if (!dev_valid) begin
                    state_d = HS_IDLE;           // release
                end
            end
            HS_WAIT_ROOM: begin
                if (!dev_valid) begin
                    state_d = HS_IDLE;           // withdraw
                end else if (!reg_full) begin
                    state_d   = HS_ACCEPT;       // take
                    take_byte = 1'b1;
                end
            end
            default: begin
                state_d = HS_IDLE;
            end
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        unique case (state_q)
            HS_ACCEPT: dev_accept = 1'b1;
            default:   dev_accept = 1'b0;
        endcase
    end

endmodule

// File: rtl/hs_hold_reg.sv
module hs_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_byte,
    input  logic [DATA_W-1:0] din,
    input  logic              clear_req,
    output logic [DATA_W-1:0] data_q,
    output logic              flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take_byte) begin
            data_q <= din;
        end
    end

    // A new byte has priority over a clear. The FSM only takes a byte while
    // the flag is clear, so both never act on a full register at once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (take_byte) begin
            flag_q <= 1'b1;
        end else if (clear_req) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/hs_cpu_port.sv
module hs_cpu_port
    import hs_in_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              cpu_addr,
    input  logic              cpu_rd,
    input  logic              flag_q,
    input  logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              clear_req
);

    localparam int PAD_W = DATA_W - 1;

    logic [DATA_W-1:0] status_word;

    assign status_word = {{PAD_W{1'b0}}, flag_q};

    always_comb begin
        unique case (cpu_addr)
            ADDR_DATA: cpu_rdata = data_q;
            default:   cpu_rdata = status_word;
        endcase
    end

    assign clear_req = cpu_rd && (cpu_addr == ADDR_DATA) && flag_q;

endmodule

// File: rtl/hs_input_port.sv
module hs_input_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dev_data,
    input  logic              dev_valid,
    output logic              dev_accept,
    input  logic              cpu_addr,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic              take_byte;
    logic              clear_req;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;

    hs_capture_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_valid  (dev_valid),
        .reg_full   (flag_q),
        .take_byte  (take_byte),
        .dev_accept (dev_accept)
    );

    hs_hold_reg #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_byte (take_byte),
        .din       (dev_data),
        .clear_req (clear_req),
        .data_q    (data_q),
        .flag_q    (flag_q)
    );

    hs_cpu_port #(.DATA_W(DATA_W)) cpu_i (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .flag_q    (flag_q),
        .data_q    (data_q),
        .cpu_rdata (cpu_rdata),
        .clear_req (clear_req)
    );

endmodule

// File: rtl/hs_input_port_chk.sv
module hs_input_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dev_valid,
    input logic              dev_accept,
    input logic              cpu_addr,
    input logic              cpu_rd,
    input logic              flag_q,
    input logic [DATA_W-1:0] data_q
);

    // R2: accepted only rises together with the flag
    a_r2_accept_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_accept) |-> $rose(flag_q));

    // R3: accepted held while valid is high
    a_r3_accept_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_accept && dev_valid) |=> dev_accept);

    // R3: accepted dropped one edge after valid goes low
    a_r3_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_accept && !dev_valid) |=> !dev_accept);

    // R4: a full register does not raise accepted
    a_r4_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !dev_accept) |=> !dev_accept);

    // R4: a full register is not overwritten
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> $stable(data_q));

    // R5: a status read leaves the flag set
    a_r5_status_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_addr && flag_q) |=> flag_q);

    // R6: a data read clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr && flag_q) |=> !flag_q);

    // R8: withdrawing valid never produces accepted
    a_r8_no_accept_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_valid && !dev_accept) |=> !dev_accept);

endmodule

bind hs_input_port hs_input_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_valid  (dev_valid),
    .dev_accept (dev_accept),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .flag_q     (flag_q),
    .data_q     (data_q)
);

// File: tb/hs_input_port_tb.sv
`timescale 1ns/1ps
module hs_input_port_tb_top;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] dev_data = '0;
    logic              dev_valid = 1'b0;
    logic              dev_accept;
    logic              cpu_addr = 1'b0;
    logic              cpu_rd = 1'b0;
    logic [DATA_W-1:0] cpu_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    hs_input_port #(.DATA_W(DATA_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_data   (dev_data),
        .dev_valid  (dev_valid),
        .dev_accept (dev_accept),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_rdata  (cpu_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Combinational reads, taken between edges with no strobe
    task automatic peek_status(output logic [DATA_W-1:0] v);
        cpu_addr = 1'b0;
        #1;
        v = cpu_rdata;
    endtask

    task automatic peek_data(output logic [DATA_W-1:0] v);
        cpu_addr = 1'b1;
        #1;
        v = cpu_rdata;
    endtask

    // Strobe a data read for one edge
    task automatic strobe_data_read();
        cpu_addr = 1'b1;
        cpu_rd   = 1'b1;
        @(negedge clk);
        cpu_rd   = 1'b0;
        cpu_addr = 1'b0;
    endtask

    // Full transfer of one byte followed by a polled read
    task automatic transfer(input logic [DATA_W-1:0] b, input int hold);
        logic [DATA_W-1:0] v;
        dev_data  = b;
        dev_valid = 1'b1;
        @(negedge clk);
        chk("R2 accept after take", 32'(dev_accept), 32'd1);
        peek_status(v);
        chk("R5 status flag set", 32'(v), 32'd1);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R3 accept held", 32'(dev_accept), 32'd1);
        end
        dev_valid = 1'b0;
        @(negedge clk);
        chk("R3 accept dropped", 32'(dev_accept), 32'd0);
        peek_data(v);
        chk("R6 data read", 32'(v), 32'(b));
        strobe_data_read();
        peek_status(v);
        chk("R6 flag cleared by read", 32'(v), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] first_b;
        logic [DATA_W-1:0] second_b;

        // R1: state during and after reset
        repeat (3) @(negedge clk);
        chk("R1 accept in reset", 32'(dev_accept), 32'd0);
        peek_status(v);
        chk("R1 flag in reset", 32'(v), 32'd0);
        peek_data(v);
        chk("R1 data in reset", 32'(v), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 accept after reset", 32'(dev_accept), 32'd0);
        peek_status(v);
        chk("R1 flag after reset", 32'(v), 32'd0);

        // R2/R3/R6: sweep all byte values with hold lengths 0..2
        for (int i = 0; i < 256; i++) begin
            transfer(DATA_W'(i), i % 3);
            repeat (i % 2) @(negedge clk);
        end

        // R4/R7: back-pressure
        first_b  = 8'hA5;
        second_b = 8'h3C;
        dev_data  = first_b;
        dev_valid = 1'b1;
        @(negedge clk);
        dev_valid = 1'b0;
        @(negedge clk);
        dev_data  = second_b;
        dev_valid = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R4 no accept while full", 32'(dev_accept), 32'd0);
            peek_data(v);
            chk("R4 data kept while full", 32'(v), 32'(first_b));
        end
        // R5: status strobe does not clear
        cpu_addr = 1'b0;
        cpu_rd   = 1'b1;
        @(negedge clk);
        cpu_rd   = 1'b0;
        peek_status(v);
        chk("R5 status strobe keeps flag", 32'(v), 32'd1);
        chk("R4 still no accept", 32'(dev_accept), 32'd0);
        // R7: the clear happens at the read edge, the take at the next one
        strobe_data_read();
        chk("R7 no accept at clear edge", 32'(dev_accept), 32'd0);
        peek_status(v);
        chk("R7 flag clear after read", 32'(v), 32'd0);
        @(negedge clk);
        chk("R7 pending byte accepted", 32'(dev_accept), 32'd1);
        peek_data(v);
        chk("R7 pending byte stored", 32'(v), 32'(second_b));
        dev_valid = 1'b0;
        @(negedge clk);
        chk("R3 accept dropped after pending", 32'(dev_accept), 32'd0);

        // R8: withdraw while held off
        dev_data  = 8'hE7;
        dev_valid = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 still full no accept", 32'(dev_accept), 32'd0);
        dev_valid = 1'b0;
        @(negedge clk);
        strobe_data_read();
        repeat (3) begin
            @(negedge clk);
            chk("R8 no accept after withdraw", 32'(dev_accept), 32'd0);
        end
        peek_status(v);
        chk("R8 flag stays clear", 32'(v), 32'd0);
        peek_data(v);
        chk("R8 withdrawn byte not stored", 32'(v), 32'(second_b));

        // R6: data strobe with empty register has no effect, then normal transfer
        strobe_data_read();
        peek_status(v);
        chk("R6 empty read keeps flag clear", 32'(v), 32'd0);
        transfer(8'h5A, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule